// File: doc/BRIEF.md
# Sliced Signed Pipelined Adder

This block adds two two's-complement operands and a one-bit carry-in and returns a signed result one bit wider than the operands, so the sum can never wrap. The carry chain is cut into equal slices, and each slice is placed in its own pipeline stage. A stage adds its slice of the operands to the carry handed over from the stage below, then registers the partial result. The operand bits that are still waiting are carried forward in the same register, so they stay aligned with that carry.

Every slice below the top one is added as an unsigned value, and its carry goes up to the next stage. Only the top slice is sign-extended. Its extra bit becomes the sign of the result. The operands are registered once at the inputs, and the last stage register drives the output directly. With the default 8-bit operands and 4-bit slices, a result appears three rising edges after its operands are presented. A new operand pair may be presented on every clock.

Top module: `sliced_signed_adder`

## Requirements
- R1: Reset is synchronous and active-high, and it clears every pipeline register; `sum` reads 0 after any rising edge sampled with `rst` high.
- R2: Operands present before rising edge n give, after edge n+2, `sum` = signed(`op_a`) + signed(`op_b`) + `carry_in` as a 9-bit two's-complement value.
- R3: `sum[8]` is the true sign of the result, equal to op_a[7] ^ op_b[7] ^ (carry out of bit 7); two operands of the same sign give a result of that sign.
- R4: Operands of mixed sign give the correct signed result, for example 5 + (-3) = 9'h002 and 3 + (-5) = 9'h1FE.
- R5: One operation is accepted on every clock, and back-to-back operations do not affect one another.
- R6: `carry_in` adds 1 at bit 0, and a carry out of the low slice reaches the high slice: 8'h0F + 8'h00 + 1 = 9'h010.
- R7: At the extremes, 127 + 127 + 1 = 9'h0FF, -128 + -128 = 9'h100 and -128 + -128 + 1 = 9'h101.
- R8: A reset asserted while operations are in flight discards them, and `sum` reads 0 at the three output samples that follow the reset edge.
- R9: Bitwise-complementary operands give -1 (9'h1FF) with `carry_in` 0 and 0 (9'h000) with `carry_in` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | OPW (8) | First signed operand |
| op_b | input | OPW (8) | Second signed operand |
| carry_in | input | 1 | Carry added at bit 0 |
| sum | output | OPW+1 (9) | Registered signed sum |

## Verification
- A stage register that drops or delays a slice carry makes the output wrong by a multiple of 16, three edges after the operand pair that crosses the slice boundary.
- An operand copy that falls out of step makes the upper nibble of the result come from the wrong operation, which shows up at once in a stream of back-to-back operations.
- A top slice extended with zeros instead of the sign bit gives a wrong `sum[8]` for every negative result.
- A register that reset does not clear shows a nonzero value among the three samples after a reset taken in the middle of a stream.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
    // default geometry: operand width and slice width (slice must divide operand)
    localparam int unsigned DEF_OPW = 8;
    localparam int unsigned DEF_SLW = 4;

    // how a stage widens its slice before the add
    typedef enum logic {
        EXT_ZERO = 1'b0,   // unsigned slice, extra bit is the carry-out
        EXT_SIGN = 1'b1    // top slice, extra bit is the result sign
    } ext_mode_e;

    function automatic int unsigned slice_count(int unsigned opw, int unsigned slw);
        return opw / slw;
    endfunction
endpackage

// File: rtl/sadd_capture.sv
module sadd_capture
    import sadd_pkg::*;
#(
    parameter int unsigned OPW = DEF_OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic           c_i,
    output logic [OPW-1:0] a_o,
    output logic [OPW-1:0] b_o,
    output logic [OPW:0]   acc_o
);
    // the carry-in sits at bit 0 of the accumulator, where stage 0 reads it
    always_ff @(posedge clk) begin
        if (rst) begin
            a_o   <= '0;
            b_o   <= '0;
            acc_o <= '0;
        end else begin
            a_o   <= a_i;
            b_o   <= b_i;
            acc_o <= {{OPW{1'b0}}, c_i};
        end
    end

    a_r1_capture_clear: assert property (@(posedge clk)
        rst |=> (a_o == '0 && b_o == '0 && acc_o == '0));
endmodule

// File: rtl/sadd_slice.sv
module sadd_slice
    import sadd_pkg::*;
#(
    parameter int unsigned OPW  = DEF_OPW,
    parameter int unsigned SLW  = DEF_SLW,
    parameter int unsigned IDX  = 0,
    parameter ext_mode_e   MODE = EXT_ZERO
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic [OPW:0]   acc_i,
    output logic [OPW-1:0] a_o,
    output logic [OPW-1:0] b_o,
    output logic [OPW:0]   acc_o
);
    localparam int unsigned LO = IDX * SLW;

    logic [SLW-1:0] a_s, b_s;
    logic           cin_s;
    logic [SLW:0]   part;
    logic [OPW:0]   acc_n;

    assign a_s   = a_i[LO +: SLW];
    assign b_s   = b_i[LO +: SLW];
    assign cin_s = acc_i[LO];          // carry parked here by the stage below

    generate
        if (MODE == EXT_ZERO) begin : g_zext
            assign part = {1'b0, a_s} + {1'b0, b_s} + {{SLW{1'b0}}, cin_s};
        end else begin : g_sext
            assign part = {a_s[SLW-1], a_s} + {b_s[SLW-1], b_s} + {{SLW{1'b0}}, cin_s};
        end
    endgenerate

    // slice sum overwrites the parked carry; the extra bit lands one slice up
    // (the next stage's carry-in, or the sign bit for the top stage)
    always_comb begin
        acc_n                = acc_i;
        acc_n[LO +: SLW + 1] = part;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_o   <= '0;
            b_o   <= '0;
            acc_o <= '0;
        end else begin
            a_o   <= a_i;
            b_o   <= b_i;
            acc_o <= acc_n;
        end
    end

    a_r1_stage_clear: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && a_o == '0 && b_o == '0));

    generate
        if (IDX > 0) begin : g_low_chk
            // result bits finished below this slice ride through untouched
            a_r5_low_bits_held: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> acc_o[LO-1:0] == $past(acc_i[LO-1:0]));
        end
    endgenerate
endmodule

// File: rtl/sliced_signed_adder.sv
module sliced_signed_adder
    import sadd_pkg::*;
#(
    parameter int unsigned OPW = DEF_OPW,
    parameter int unsigned SLW = DEF_SLW    // must divide OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    input  logic           carry_in,
    output logic [OPW:0]   sum
);
    localparam int NSEG = int'(slice_count(OPW, SLW));

    logic [OPW-1:0] a_p   [NSEG+1];
    logic [OPW-1:0] b_p   [NSEG+1];
    logic [OPW:0]   acc_p [NSEG+1];

    sadd_capture #(.OPW(OPW)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .a_i   (op_a),
        .b_i   (op_b),
        .c_i   (carry_in),
        .a_o   (a_p[0]),
        .b_o   (b_p[0]),
        .acc_o (acc_p[0])
    );

    generate
        for (genvar k = 0; k < NSEG; k++) begin : g_stage
            sadd_slice #(
                .OPW  (OPW),
                .SLW  (SLW),
                .IDX  (k),
                .MODE ((k == NSEG - 1) ? EXT_SIGN : EXT_ZERO)
            ) u_slice (
                .clk   (clk),
                .rst   (rst),
                .a_i   (a_p[k]),
                .b_i   (b_p[k]),
                .acc_i (acc_p[k]),
                .a_o   (a_p[k+1]),
                .b_o   (b_p[k+1]),
                .acc_o (acc_p[k+1])
            );
        end
    endgenerate

    assign sum = acc_p[NSEG];

    // a_p/b_p at the last index are the operands that produced the current sum
    a_r1_sum_clear: assert property (@(posedge clk) rst |=> sum == '0);

    a_r3_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (a_p[NSEG][OPW-1] == b_p[NSEG][OPW-1]) |-> sum[OPW] == a_p[NSEG][OPW-1]);

    a_r9_complement: assert property (@(posedge clk) disable iff (rst)
        (a_p[NSEG] == ~b_p[NSEG]) |-> (sum == '1 || sum == '0));
endmodule

// File: tb/tb_sliced_signed_adder.sv
`timescale 1ns/1ps
module tb_sliced_signed_adder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic       carry_in = 1'b0;
    logic [8:0] sum;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    sliced_signed_adder dut (
        .clk      (clk),
        .rst      (rst),
        .op_a     (op_a),
        .op_b     (op_b),
        .carry_in (carry_in),
        .sum      (sum)
    );

    // {a, b, cin, expected}
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {8'h05, 8'h03, 1'b0, 9'h008},
        {8'h0F, 8'h00, 1'b1, 9'h010},
        {8'h7F, 8'h7F, 1'b1, 9'h0FF},
        {8'h80, 8'h80, 1'b0, 9'h100},
        {8'h80, 8'h80, 1'b1, 9'h101},
        {8'h05, 8'hFD, 1'b0, 9'h002},
        {8'h03, 8'hFB, 1'b0, 9'h1FE},
        {8'hFF, 8'h01, 1'b0, 9'h000},
        {8'hFF, 8'hFF, 1'b1, 9'h1FF},
        {8'h7F, 8'h80, 1'b0, 9'h1FF},
        {8'h00, 8'h00, 1'b1, 9'h001},
        {8'h64, 8'h32, 1'b0, 9'h096}
    };
    string VTAG [NV] = '{"R2", "R6", "R7", "R7", "R7", "R4",
                         "R4", "R4", "R3", "R9", "R6", "R5"};

    // expected results in flight, slot 2 is due at this sample
    logic [8:0] s_exp [3];
    bit         s_vld [3] = '{0, 0, 0};
    string      s_tag [3];

    function automatic logic [8:0] ref_sum(logic [7:0] a, logic [7:0] b, logic c);
        return {a[7], a} + {b[7], b} + {8'd0, c};
    endfunction

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // one call per clock: check due result, then present a new operation
    task automatic step(input logic [7:0] a, input logic [7:0] b, input logic c,
                        input bit chk, input string tag, input bit r);
        @(negedge clk);
        if (s_vld[2]) begin
            n_chk++;
            if (sum !== s_exp[2]) begin
                n_fail++;
                $display("FAIL %s: sum actual %h expected %h", s_tag[2], sum, s_exp[2]);
            end
        end
        for (int i = 2; i > 0; i--) begin
            s_exp[i] = s_exp[i-1];
            s_vld[i] = s_vld[i-1];
            s_tag[i] = s_tag[i-1];
        end
        s_exp[0] = ref_sum(a, b, c);
        s_vld[0] = chk;
        s_tag[0] = tag;
        if (r) begin
            // reset at the coming edge flushes everything still in flight
            for (int i = 0; i < 3; i++) begin
                s_exp[i] = '0;
                s_vld[i] = 1'b1;
                s_tag[i] = (tag == "R1") ? "R1" : "R8";
            end
        end
        op_a     = a;
        op_b     = b;
        carry_in = c;
        rst      = r;
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    initial begin
        logic [7:0] sa, sb;
        // R1: reset state, operands driven but ignored while reset is high
        for (int i = 0; i < 5; i++) step(8'h5A, 8'h33, 1'b1, 1'b1, "R1", 1'b1);

        // R2 R4 R5 R6 R7 R9: vector table, back to back
        for (int i = 0; i < NV; i++)
            step(VEC[i][25:18], VEC[i][17:10], VEC[i][9], 1'b1, VTAG[i], 1'b0);

        // R9: complementary pairs with both carry values
        step(8'h3C, 8'hC3, 1'b0, 1'b1, "R9", 1'b0);
        step(8'hA5, 8'h5A, 1'b1, 1'b1, "R9", 1'b0);

        // R4 R5: rising a, falling b sweep crossing both signs
        sa = 8'h00;
        sb = 8'h00;
        for (int i = 0; i < 260; i++) begin
            step(sa, sb, 1'(i % 3 == 0), 1'b1, "R4", 1'b0);
            sa = sa + 8'd1;
            sb = sb - 8'd2;
        end

        // R8: reset in the middle of a stream
        step(8'h11, 8'h22, 1'b0, 1'b1, "R8", 1'b0);
        step(8'h7E, 8'h81, 1'b1, 1'b1, "R8", 1'b0);
        step(8'h44, 8'h01, 1'b1, 1'b1, "R8", 1'b1);
        step(8'h12, 8'h34, 1'b0, 1'b1, "R8", 1'b0);

        // R2 R3: random operands
        for (int i = 0; i < 400; i++)
            step(8'($urandom), 8'($urandom), 1'($urandom), 1'b1, "R3", 1'b0);

        // drain the pipeline
        for (int i = 0; i < 3; i++) step(8'h00, 8'h00, 1'b0, 1'b0, "R2", 1'b0);

        report();
        $finish;
    end
endmodule